// File: doc/BRIEF.md
# Storage Adapter Host Register Block

This block is the host-facing register file of a storage host adapter. It sits on a simple 32-bit bus with separate write and read strobes. Read data comes back one clock after the read strobe. It reports the adapter's firmware condition through two scratch-pad words. It gates an outbound status word on the interrupt enable and on a pending doorbell. The host can clear doorbell bits and program an interrupt mask.

Writes to the inbound queue port are turned into a frame request for the command engine. The request carries a 64-bit frame address and a 4-bit frame count and is held for one clock. The upper address word is stored beforehand through a separate register.

Two paths lead to a soft reset. One is a mask write that leaves interrupts off. The other is a diagnostic write made after a six-word unlock sequence has been written to a key register. Either path returns the firmware state to ready, clears the doorbell and relocks the diagnostic register. The command engine raises doorbell bits through a side input.

Top module: `sc_host_regs`

## Requirements
- R1: While reset is held, and on the first clock after it, `rdata`, `frame_req` and `soft_rst` are all zero.
- R2: A read of offset 0xB0 returns a packed word. Bits [31:28] hold the firmware state (ready = 0xB, fault = 0xF). Bit 27 is set when `HAS_MSIX` is 1. Bits [23:16] hold the low 8 bits of `SGE_LIMIT`, and bits [15:0] hold the low 16 bits of `CMD_LIMIT`. With the default parameters and in the ready state this word is 0xB85003F0.
- R3: A read of offset 0xB4 always returns 15.
- R4: A read of offset 0x30 returns `STATUS_CODE` (default 0x20000001) only when the mask at 0x34 is not 0xFFFFFFFF and the doorbell is nonzero. In every other case it returns 0.
- R5: Each bit set on `db_set` in a cycle is ORed into the doorbell. A read of 0xA0 returns the doorbell. A write to 0xA0 clears the doorbell bits that are 1 in the written word.
- R6: A write to 0xC0 raises `frame_req` for exactly the next clock. In that clock, `frame_addr` is the stored upper word in bits [63:32] and the written word with bits [4:0] cleared in bits [31:0]. `frame_cnt` is written bits [4:1].
- R7: A write to 0xC4 stores the upper address word and raises no frame request.
- R8: A write to 0x10 with bit 5 set moves the firmware state to fault, which then reads as 0xF in bits [31:28] of 0xB0.
- R9: The mask resets to 0xFFFFFFFF and reads back at 0x34. Writing 0xFFFFFFFF there pulses `soft_rst` on the next clock; writing any other value does not. A soft reset returns the state to ready and clears the doorbell.
- R10: Writing 0x0, 0x4, 0xB, 0x2, 0x7, 0xD in that order to offset 0x04 makes offset 0xF8 read 0x80. Any key write that breaks the order, or any key write made once unlocked, relocks the register so that it reads 0.
- R11: A write to 0xF8 with bit 2 set performs a soft reset (with the `soft_rst` pulse) and relocks, but only while unlocked. The same write while locked has no effect.
- R12: Reads of any other offset return 0. Writes to any other offset change nothing that can be read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the clock after `rd_en` |
| db_set | input | 32 | Doorbell bits raised by the command engine |
| frame_req | output | 1 | One-clock frame request strobe |
| frame_addr | output | 64 | Decoded frame address |
| frame_cnt | output | CNT_W | Decoded frame count |
| soft_rst | output | 1 | One-clock soft reset pulse |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high together. They also assume that `addr` and `wdata` are stable for the whole clock in which a strobe is high, since every property compares a registered result against the access of the previous clock. The bench drives one access at a time on the falling edge, and holds `db_set` at zero around reads of the status and doorbell words, so each property's premise refers to a single access. Doorbell raises are applied as isolated one-clock pulses between bus accesses.

// File: rtl/sc_host_regs_pkg.sv
package sc_host_regs_pkg;

  localparam int DW      = 32;
  localparam int OFS_W   = 8;
  localparam int KEY_LEN = 6;

  localparam logic [OFS_W-1:0] OFS_KEY    = 8'h04;
  localparam logic [OFS_W-1:0] OFS_INIT   = 8'h10;
  localparam logic [OFS_W-1:0] OFS_STATUS = 8'h30;
  localparam logic [OFS_W-1:0] OFS_MASK   = 8'h34;
  localparam logic [OFS_W-1:0] OFS_DBCLR  = 8'hA0;
  localparam logic [OFS_W-1:0] OFS_SP0    = 8'hB0;
  localparam logic [OFS_W-1:0] OFS_SP1    = 8'hB4;
  localparam logic [OFS_W-1:0] OFS_QLO    = 8'hC0;
  localparam logic [OFS_W-1:0] OFS_QHI    = 8'hC4;
  localparam logic [OFS_W-1:0] OFS_DIAG   = 8'hF8;

  localparam int          INIT_FAULT_BIT = 5;
  localparam int          DIAG_WE_BIT    = 7;
  localparam int          DIAG_RST_BIT   = 2;
  localparam int          MSIX_CAP_BIT   = 27;
  localparam logic [DW-1:0] SP1_VALUE    = 32'd15;
  localparam logic [DW-1:0] MASK_ALL_OFF = '1;

  typedef enum logic [3:0] {
    FW_READY = 4'hB,
    FW_FAULT = 4'hF
  } fw_state_e;

  typedef struct packed {
    logic key;
    logic init;
    logic status;
    logic mask;
    logic dbclr;
    logic sp0;
    logic sp1;
    logic qlo;
    logic qhi;
    logic diag;
  } reg_sel_t;

  function automatic logic [DW-1:0] pack_scratch0(input fw_state_e st,
                                                  input logic msix,
                                                  input logic [7:0] sge,
                                                  input logic [15:0] cmd);
    logic [DW-1:0] w;
    w = '0;
    w[31:28] = st;
    w[MSIX_CAP_BIT] = msix;
    w[23:16] = sge;
    w[15:0] = cmd;
    return w;
  endfunction

  function automatic logic [2*DW-1:0] frame_address(input logic [DW-1:0] hi,
                                                    input logic [DW-1:0] lo);
    return {hi, lo[DW-1:5], 5'b00000};
  endfunction

  function automatic logic [3:0] frame_count(input logic [DW-1:0] w);
    return w[4:1];
  endfunction

  function automatic logic [DW-1:0] key_step(input int idx);
    case (idx)
      0: return 32'h0;
      1: return 32'h4;
      2: return 32'hB;
      3: return 32'h2;
      4: return 32'h7;
      default: return 32'hD;
    endcase
  endfunction

endpackage

// File: rtl/sc_addr_decode.sv
module sc_addr_decode
  import sc_host_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel,
  output logic              hit
);
  function automatic logic at(input logic [ADDR_W-1:0] a, input logic [OFS_W-1:0] o);
    return a == ADDR_W'(o);
  endfunction

  always_comb begin
    sel.key    = at(addr, OFS_KEY);
    sel.init   = at(addr, OFS_INIT);
    sel.status = at(addr, OFS_STATUS);
    sel.mask   = at(addr, OFS_MASK);
    sel.dbclr  = at(addr, OFS_DBCLR);
    sel.sp0    = at(addr, OFS_SP0);
    sel.sp1    = at(addr, OFS_SP1);
    sel.qlo    = at(addr, OFS_QLO);
    sel.qhi    = at(addr, OFS_QHI);
    sel.diag   = at(addr, OFS_DIAG);
    hit        = |sel;
  end
endmodule

// File: rtl/sc_diag_unlock.sv
module sc_diag_unlock
  import sc_host_regs_pkg::*;
#(
  parameter int SEQ_LEN = KEY_LEN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          key_wr,
  input  logic          diag_wr,
  input  logic [DW-1:0] wdata,
  output logic          unlocked,
  output logic          rst_req
);
  localparam int PW = $clog2(SEQ_LEN + 1);

  logic [PW-1:0] prog_q;
  logic          step_ok;

  assign unlocked = (prog_q == PW'(SEQ_LEN));
  assign step_ok  = !unlocked && (wdata == key_step(int'(prog_q)));
  assign rst_req  = diag_wr && unlocked && wdata[DIAG_RST_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= '0;
    end else if (clr || rst_req) begin
      prog_q <= '0;
    end else if (key_wr) begin
      prog_q <= step_ok ? prog_q + 1'b1 : '0;
    end
  end
endmodule

// File: rtl/sc_qport.sv
module sc_qport
  import sc_host_regs_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hi_wr,
  input  logic            lo_wr,
  input  logic [DW-1:0]   wdata,
  output logic            frame_req,
  output logic [2*DW-1:0] frame_addr,
  output logic [CNT_W-1:0] frame_cnt
);
  logic [DW-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q       <= '0;
      frame_req  <= 1'b0;
      frame_addr <= '0;
      frame_cnt  <= '0;
    end else begin
      frame_req <= lo_wr;
      if (hi_wr) hi_q <= wdata;
      if (lo_wr) begin
        frame_addr <= frame_address(hi_q, wdata);
        frame_cnt  <= CNT_W'(frame_count(wdata));
      end
    end
  end
endmodule

// File: rtl/sc_host_regs.sv
module sc_host_regs
  import sc_host_regs_pkg::*;
#(
  parameter int              ADDR_W      = 8,
  parameter int              CNT_W       = 4,
  parameter int unsigned     CMD_LIMIT   = 1008,
  parameter int unsigned     SGE_LIMIT   = 80,
  parameter bit              HAS_MSIX    = 1'b1,
  parameter logic [31:0]     STATUS_CODE = 32'h2000_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [31:0]       db_set,
  output logic              frame_req,
  output logic [63:0]       frame_addr,
  output logic [CNT_W-1:0]  frame_cnt,
  output logic              soft_rst
);
  localparam logic [7:0]  SGE_FIELD = 8'(SGE_LIMIT);
  localparam logic [15:0] CMD_FIELD = 16'(CMD_LIMIT);

  reg_sel_t      sel;
  logic          rd_hit;
  reg_sel_t      wr_sel;
  fw_state_e     fw_state_q;
  logic [DW-1:0] db_q;
  logic [DW-1:0] mask_q;
  logic          intr_en;
  logic          mask_off_wr;
  logic          diag_rst_req;
  logic          soft_rst_req;
  logic          unlocked;
  logic [DW-1:0] rd_val;

  sc_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (addr),
    .sel  (sel),
    .hit  (rd_hit)
  );

  assign wr_sel       = wr_en ? sel : '0;
  assign intr_en      = (mask_q != MASK_ALL_OFF);
  assign mask_off_wr  = wr_sel.mask && (wdata == MASK_ALL_OFF);
  assign soft_rst_req = mask_off_wr || diag_rst_req;

  sc_diag_unlock #(.SEQ_LEN(KEY_LEN)) u_unlock (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (mask_off_wr),
    .key_wr   (wr_sel.key),
    .diag_wr  (wr_sel.diag),
    .wdata    (wdata),
    .unlocked (unlocked),
    .rst_req  (diag_rst_req)
  );

  sc_qport #(.CNT_W(CNT_W)) u_qport (
    .clk        (clk),
    .rst_n      (rst_n),
    .hi_wr      (wr_sel.qhi),
    .lo_wr      (wr_sel.qlo),
    .wdata      (wdata),
    .frame_req  (frame_req),
    .frame_addr (frame_addr),
    .frame_cnt  (frame_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fw_state_q <= FW_READY;
    end else if (soft_rst_req) begin
      fw_state_q <= FW_READY;
    end else if (wr_sel.init && wdata[INIT_FAULT_BIT]) begin
      fw_state_q <= FW_FAULT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db_q <= '0;
    end else if (soft_rst_req) begin
      db_q <= '0;
    end else begin
      db_q <= (db_q & ~(wr_sel.dbclr ? wdata : '0)) | db_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= MASK_ALL_OFF;
    end else if (wr_sel.mask) begin
      mask_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) soft_rst <= 1'b0;
    else        soft_rst <= soft_rst_req;
  end

  always_comb begin
    rd_val = '0;
    if (sel.sp0)    rd_val = pack_scratch0(fw_state_q, HAS_MSIX, SGE_FIELD, CMD_FIELD);
    if (sel.sp1)    rd_val = SP1_VALUE;
    if (sel.status) rd_val = (intr_en && (db_q != '0)) ? STATUS_CODE : '0;
    if (sel.mask)   rd_val = mask_q;
    if (sel.dbclr)  rd_val = db_q;
    if (sel.diag)   rd_val = DW'(unlocked) << DIAG_WE_BIT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_en ? rd_val : '0;
  end
endmodule

// File: rtl/sc_host_regs_chk.sv
module sc_host_regs_chk
  import sc_host_regs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              frame_req,
  input logic [63:0]       frame_addr,
  input logic [CNT_W-1:0]  frame_cnt,
  input logic              soft_rst,
  input logic              rd_hit,
  input logic [31:0]       mask_q,
  input logic [31:0]       db_q,
  input logic [3:0]        fw_state_q
);
  // R6
  frame_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_req |-> $past(wr_en && addr == ADDR_W'(OFS_QLO)));

  // R6
  frame_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_req |-> frame_cnt == CNT_W'($past(wdata[4:1])));

  // R6
  frame_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_req |-> frame_addr[4:0] == 5'b0);

  // R3
  scratch1_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(OFS_SP1)) |=> rdata == 32'd15);

  // R12
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_hit) |=> rdata == 32'd0);

  // R4
  status_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(OFS_STATUS) && (mask_q == '1 || db_q == '0)) |=> rdata == 32'd0);

  // R8
  fault_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(OFS_INIT) && wdata[INIT_FAULT_BIT]) |=> fw_state_q == FW_FAULT);

  // R9
  mask_off_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(OFS_MASK) && wdata == '1) |=> (soft_rst && db_q == '0 && fw_state_q == FW_READY));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (rdata == '0 && !frame_req && !soft_rst));
endmodule

bind sc_host_regs sc_host_regs_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .addr       (addr),
  .wdata      (wdata),
  .rdata      (rdata),
  .frame_req  (frame_req),
  .frame_addr (frame_addr),
  .frame_cnt  (frame_cnt),
  .soft_rst   (soft_rst),
  .rd_hit     (rd_hit),
  .mask_q     (mask_q),
  .db_q       (db_q),
  .fw_state_q (fw_state_q)
);

// File: tb/sc_host_regs_bench.sv
module sc_host_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] db_set = '0;
  logic        frame_req;
  logic [63:0] frame_addr;
  logic [3:0]  frame_cnt;
  logic        soft_rst;

  int total = 0;
  int fails = 0;

  localparam logic [31:0] SP0_READY = 32'hB850_03F0;
  localparam logic [31:0] SP0_FAULT = 32'hF850_03F0;
  localparam logic [31:0] STATUS    = 32'h2000_0001;

  always #5 clk = ~clk;

  sc_host_regs u_sc_host_regs (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .rd_en (rd_en),
    .addr (addr), .wdata (wdata), .rdata (rdata), .db_set (db_set),
    .frame_req (frame_req), .frame_addr (frame_addr),
    .frame_cnt (frame_cnt), .soft_rst (soft_rst)
  );

  typedef struct packed {
    logic        is_rd;
    logic [7:0]  ofs;
    logic [31:0] val;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'hB0, SP0_READY,     8'd2},   // R2
    '{1'b1, 8'hB4, 32'd15,        8'd3},   // R3
    '{1'b1, 8'h30, 32'd0,         8'd4},   // R4 masked, no doorbell
    '{1'b1, 8'h34, 32'hFFFF_FFFF, 8'd9},   // R9 mask reset value
    '{1'b1, 8'h20, 32'd0,         8'd12},  // R12
    '{1'b0, 8'h20, 32'hDEAD_BEEF, 8'd12},
    '{1'b1, 8'h20, 32'd0,         8'd12},
    '{1'b1, 8'hF8, 32'd0,         8'd10},  // R10 locked
    '{1'b0, 8'h04, 32'h0,         8'd10},
    '{1'b0, 8'h04, 32'h4,         8'd10},
    '{1'b0, 8'h04, 32'hB,         8'd10},
    '{1'b0, 8'h04, 32'h2,         8'd10},
    '{1'b0, 8'h04, 32'h7,         8'd10},
    '{1'b0, 8'h04, 32'hD,         8'd10},
    '{1'b1, 8'hF8, 32'h80,        8'd10},
    '{1'b0, 8'h04, 32'h5,         8'd10},
    '{1'b1, 8'hF8, 32'd0,         8'd10},
    '{1'b0, 8'h34, 32'h0,         8'd9},
    '{1'b1, 8'h34, 32'h0,         8'd9},
    '{1'b1, 8'h30, 32'd0,         8'd4},   // R4 enabled, no doorbell
    '{1'b0, 8'h10, 32'h20,        8'd8},   // R8
    '{1'b1, 8'hB0, SP0_FAULT,     8'd8},
    '{1'b1, 8'hA0, 32'd0,         8'd5}    // R5
  };

  task automatic chk(input int req, input logic [63:0] act, input logic [63:0] exp, input string what);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] o, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = o; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] o, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = o;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic unlock();
    bus_wr(8'h04, 32'h0); bus_wr(8'h04, 32'h4); bus_wr(8'h04, 32'hB);
    bus_wr(8'h04, 32'h2); bus_wr(8'h04, 32'h7); bus_wr(8'h04, 32'hD);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL R1 watchdog expired: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset and on the first clock after it
    chk(1, {rdata, 29'd0, frame_req, soft_rst, 1'b0}, 64'd0, "reset outputs");
    rst_n = 1'b1;
    @(negedge clk);
    chk(1, {rdata, 29'd0, frame_req, soft_rst, 1'b0}, 64'd0, "after reset");

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].is_rd) begin
        bus_rd(VECS[i].ofs, r);
        chk(int'(VECS[i].req), 64'(r), 64'(VECS[i].val), $sformatf("vector %0d", i));
      end else begin
        bus_wr(VECS[i].ofs, VECS[i].val);
      end
    end

    // R5: doorbell raise and write-1-to-clear
    @(negedge clk); db_set = 32'h5;
    @(negedge clk); db_set = 32'h0;
    bus_rd(8'hA0, r); chk(5, 64'(r), 64'h5, "doorbell raised");
    // R4: enabled and doorbell pending
    bus_rd(8'h30, r); chk(4, 64'(r), 64'(STATUS), "status gated on");
    bus_wr(8'hA0, 32'h1);
    bus_rd(8'hA0, r); chk(5, 64'(r), 64'h4, "doorbell partial clear");

    // R9: mask off issues soft reset
    bus_wr(8'h34, 32'hFFFF_FFFF);
    chk(9, 64'(soft_rst), 64'd1, "soft reset pulse on mask off");
    @(negedge clk);
    chk(9, 64'(soft_rst), 64'd0, "soft reset one clock");
    bus_rd(8'h30, r); chk(4, 64'(r), 64'd0, "status with mask off");
    bus_rd(8'hA0, r); chk(9, 64'(r), 64'd0, "doorbell cleared by soft reset");
    bus_rd(8'hB0, r); chk(9, 64'(r), 64'(SP0_READY), "state ready after soft reset");
    bus_wr(8'h34, 32'h0000_00F0);
    chk(9, 64'(soft_rst), 64'd0, "no pulse on enabling mask");

    // R7 and R6: queue port decode
    bus_wr(8'hC4, 32'h0000_00AB);
    chk(7, 64'(frame_req), 64'd0, "high word write raises no request");
    bus_wr(8'hC0, 32'h1234_567F);
    chk(6, 64'(frame_req), 64'd1, "frame request strobe");
    chk(6, frame_addr, 64'h0000_00AB_1234_5660, "frame address");
    chk(6, 64'(frame_cnt), 64'hF, "frame count");
    @(negedge clk);
    chk(6, 64'(frame_req), 64'd0, "strobe lasts one clock");
    bus_wr(8'hC0, 32'h0000_0026);
    chk(6, frame_addr, 64'h0000_00AB_0000_0020, "second frame address");
    chk(6, 64'(frame_cnt), 64'h3, "second frame count");

    // R11: diagnostic reset while locked has no effect
    bus_wr(8'h10, 32'h20);
    bus_wr(8'hF8, 32'h4);
    chk(11, 64'(soft_rst), 64'd0, "locked diag write ignored");
    bus_rd(8'hB0, r); chk(11, 64'(r), 64'(SP0_FAULT), "state kept while locked");
    // R11: unlocked diagnostic reset
    unlock();
    bus_wr(8'hF8, 32'h4);
    chk(11, 64'(soft_rst), 64'd1, "unlocked diag reset pulse");
    bus_rd(8'hF8, r); chk(11, 64'(r), 64'd0, "relocked after diag reset");
    bus_rd(8'hB0, r); chk(11, 64'(r), 64'(SP0_READY), "state ready after diag reset");
    // R10: key write after unlock relocks
    unlock();
    bus_wr(8'h04, 32'h0);
    bus_rd(8'hF8, r); chk(10, 64'(r), 64'd0, "key write after unlock relocks");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule